// File: doc/BRIEF.md
# Self-Routing Omega Switching Network

This block is an eight-port multistage interconnect that carries request messages from requester ports to memory-side ports. It is built from three ranks of four 2x2 switching elements. Each rank is preceded by a perfect-shuffle permutation of the lines. Each switch steers a message by one bit of its destination field. As the message passes, the switch writes the number of the input it arrived on over that bit. When the message leaves the network, its destination field therefore holds the path back to its sender.

Every switch output has a one-cycle register, and every port uses a valid/ready handshake. When two messages need the same switch output in the same cycle, the message on the upper input goes first. The other message waits in place until the output frees up. The network is blocking: some sets of destinations cannot all move at once, while pairs on disjoint paths move in parallel.

Top module: `omega_network`

## Requirements
- R1: After reset, every out_valid bit is 0 and every in_ready bit is 1.
- R2: A message leaves on the output port whose index equals the destination field it carried on entry. A message is the vector {dest[MOD_W], addr[ADDR_W], op[1], value[DATA_W]}, MSB first. Each stage i routes on dest bit (MOD_W-1-i): 0 selects the upper output and 1 the lower.
- R3: On delivery, the destination field holds the index of the input port the message entered on. Each stage i writes its arrival line (0 upper, 1 lower) into dest bit position (MOD_W-1-i), so the field reads the return path from MSB to LSB.
- R4: The addr, op (0 read, 1 write) and value fields arrive unchanged.
- R5: A message that meets no contention is accepted at one clock edge and is visible on out_valid after the third edge, which is a latency of 3 cycles.
- R6: Messages whose paths share no switch output, and which are offered in the same cycle, are delivered in the same cycle.
- R7: When two messages need the same switch output in the same cycle, the message on the upper input wins. The loser is delivered one cycle later with its fields intact.
- R8: A port whose message loses at the first stage sees in_ready low until it is granted. While in_valid is high and in_ready is low, the sender keeps in_valid and in_msg steady.
- R9: While out_ready is low, out_valid stays high and out_msg stays stable on that port.
- R10: Every accepted message is delivered exactly once. The network never holds more than MOD_W*N_PORTS messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N_PORTS | Request offered on each input port |
| in_msg | input | N_PORTS*MSG_W | Message per input port, port p at bits [p*MSG_W +: MSG_W] |
| in_ready | output | N_PORTS | Network takes the message on each input port |
| out_valid | output | N_PORTS | Message present on each output port |
| out_msg | output | N_PORTS*MSG_W | Delivered message per output port, dest field holding the return path |
| out_ready | input | N_PORTS | Receiver takes the message on each output port |

## Verification
A wrong shuffle wiring or a wrong routing bit sends a message to the wrong output port within three cycles. It also leaves a return-path field that no longer equals the sender index, so both faults show on the first delivery. A faulty arbiter shows up as a lost, duplicated or reordered message, or as a loser that arrives in the wrong cycle, one or two cycles after the conflict. A faulty stall path shows as an output message that changes while out_ready is low, or as an input that is accepted while its winner holds the output.

// File: rtl/omega_pkg.sv
// Package: shared helpers for the omega network.
// Assumes port counts are powers of two.
package omega_pkg;

    // Operation code carried in the op field of a message.
    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } omega_op_e;

    // Perfect-shuffle target line: rotate the line index left by one bit.
    function automatic int unsigned shuffle_line(input int unsigned line,
                                                 input int unsigned width);
        return ((line << 1) | (line >> (width - 1))) & ((1 << width) - 1);
    endfunction

endpackage

// File: rtl/omega_pipe_reg.sv
// Module: one-entry pipeline register with valid/ready flow control.
// Accepts new data when empty or when its content drains in the same cycle.
module omega_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fill,
    input  logic [W-1:0] fill_data,
    input  logic         drain,
    output logic         open,
    output logic         hold_valid,
    output logic [W-1:0] hold_data
);
    // Room is available when empty or when the receiver takes the content now.
    assign open = !hold_valid || drain;

    // Load or refill the slot; hold it while the receiver stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (open) begin
            hold_valid <= fill;
            hold_data  <= fill_data;
        end
    end
endmodule

// File: rtl/omega_switch.sv
// Module: registered 2x2 switching element.
// Routes each input by the message bit at SEL_POS: 0 goes to the upper output
// and 1 to the lower output. Overwrites that bit with the arrival input number.
// When both inputs want one output, the upper input wins and the lower stalls.
module omega_switch #(
    parameter int MSG_W   = 16,
    parameter int SEL_POS = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            in_valid,
    input  logic [1:0][MSG_W-1:0] in_msg,
    output logic [1:0]            in_ready,
    output logic [1:0]            out_valid,
    output logic [1:0][MSG_W-1:0] out_msg,
    input  logic [1:0]            out_ready
);
    logic [1:0]            route;
    logic [1:0][MSG_W-1:0] stamped;
    logic [1:0]            want_up;
    logic [1:0]            want_lo;
    logic [1:0]            open;
    logic [1:0]            fill;
    logic [1:0][MSG_W-1:0] fill_data;

    for (genvar i = 0; i < 2; i++) begin : g_in
        assign route[i] = in_msg[i][SEL_POS];
        // Replace the consumed routing bit with this input's number.
        always_comb begin
            stamped[i]          = in_msg[i];
            stamped[i][SEL_POS] = 1'(i);
        end
    end

    for (genvar o = 0; o < 2; o++) begin : g_out
        assign want_up[o]   = in_valid[0] && (route[0] == 1'(o));
        assign want_lo[o]   = in_valid[1] && (route[1] == 1'(o));
        assign fill[o]      = want_up[o] || want_lo[o];
        assign fill_data[o] = want_up[o] ? stamped[0] : stamped[1];

        omega_pipe_reg #(.W(MSG_W)) u_reg (
            .clk        (clk),
            .rst_n      (rst_n),
            .fill       (fill[o]),
            .fill_data  (fill_data[o]),
            .drain      (out_ready[o]),
            .open       (open[o]),
            .hold_valid (out_valid[o]),
            .hold_data  (out_msg[o])
        );
    end

    // Upper input: proceeds whenever its chosen output has room.
    assign in_ready[0] = open[route[0]];
    // Lower input: also yields to a valid upper input aiming at the same output.
    assign in_ready[1] = open[route[1]] && !(in_valid[0] && (route[0] == route[1]));
endmodule

// File: rtl/omega_stage.sv
// Module: one rank of the omega network.
// Applies the perfect shuffle to the incoming lines, then feeds N_PORTS/2
// switches that all route on the message bit at SEL_POS.
module omega_stage #(
    parameter int N_PORTS = 8,
    parameter int MSG_W   = 16,
    parameter int SEL_POS = 15
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          in_valid,
    input  logic [N_PORTS-1:0][MSG_W-1:0] in_msg,
    output logic [N_PORTS-1:0]          in_ready,
    output logic [N_PORTS-1:0]          out_valid,
    output logic [N_PORTS-1:0][MSG_W-1:0] out_msg,
    input  logic [N_PORTS-1:0]          out_ready
);
    localparam int IDX_W = $clog2(N_PORTS);
    localparam int N_SW  = N_PORTS / 2;

    logic [N_PORTS-1:0]            sh_valid;
    logic [N_PORTS-1:0]            sh_ready;
    logic [N_PORTS-1:0][MSG_W-1:0] sh_msg;

    // Shuffle wiring: line p lands on line rotl(p); ready travels back the same way.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_shuffle
        localparam int Q = int'(omega_pkg::shuffle_line(p, IDX_W));
        assign sh_valid[Q] = in_valid[p];
        assign sh_msg[Q]   = in_msg[p];
        assign in_ready[p] = sh_ready[Q];
    end

    for (genvar j = 0; j < N_SW; j++) begin : g_sw
        omega_switch #(.MSG_W(MSG_W), .SEL_POS(SEL_POS)) u_sw (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (sh_valid[2*j +: 2]),
            .in_msg    (sh_msg[2*j +: 2]),
            .in_ready  (sh_ready[2*j +: 2]),
            .out_valid (out_valid[2*j +: 2]),
            .out_msg   (out_msg[2*j +: 2]),
            .out_ready (out_ready[2*j +: 2])
        );
    end
endmodule

// File: rtl/omega_network.sv
// Module: self-routing omega network, N_PORTS in and N_PORTS out.
// Chains log2(N_PORTS) shuffle-plus-switch ranks. Rank s routes on destination
// bit (MOD_W-1-s) and records the arrival line there for the return path.
// Message layout, MSB first: {dest, addr, op, value}.
module omega_network #(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PORTS-1:0]         in_valid,
    input  logic [N_PORTS*(($clog2(N_PORTS))+ADDR_W+1+DATA_W)-1:0] in_msg,
    output logic [N_PORTS-1:0]         in_ready,
    output logic [N_PORTS-1:0]         out_valid,
    output logic [N_PORTS*(($clog2(N_PORTS))+ADDR_W+1+DATA_W)-1:0] out_msg,
    input  logic [N_PORTS-1:0]         out_ready
);
    localparam int MOD_W  = $clog2(N_PORTS);
    localparam int MSG_W  = MOD_W + ADDR_W + 1 + DATA_W;
    localparam int STAGES = MOD_W;

    logic [N_PORTS-1:0]            lvl_valid [STAGES+1];
    logic [N_PORTS-1:0]            lvl_ready [STAGES+1];
    logic [N_PORTS-1:0][MSG_W-1:0] lvl_msg   [STAGES+1];

    // Network edges: inputs feed level 0, the last level drives the outputs.
    assign lvl_valid[0]      = in_valid;
    assign lvl_msg[0]        = in_msg;
    assign in_ready          = lvl_ready[0];
    assign out_valid         = lvl_valid[STAGES];
    assign out_msg           = lvl_msg[STAGES];
    assign lvl_ready[STAGES] = out_ready;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        omega_stage #(
            .N_PORTS (N_PORTS),
            .MSG_W   (MSG_W),
            .SEL_POS (MSG_W - 1 - s)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (lvl_valid[s]),
            .in_msg    (lvl_msg[s]),
            .in_ready  (lvl_ready[s]),
            .out_valid (lvl_valid[s+1]),
            .out_msg   (lvl_msg[s+1]),
            .out_ready (lvl_ready[s+1])
        );
    end
endmodule

// File: rtl/omega_network_chk.sv
// Module: assertion checker bound to omega_network.
// Tracks the number of messages in flight and checks the port protocol and
// the first-rank priority rule.
module omega_network_chk #(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_PORTS-1:0]         in_valid,
    input logic [N_PORTS*(($clog2(N_PORTS))+ADDR_W+1+DATA_W)-1:0] in_msg,
    input logic [N_PORTS-1:0]         in_ready,
    input logic [N_PORTS-1:0]         out_valid,
    input logic [N_PORTS*(($clog2(N_PORTS))+ADDR_W+1+DATA_W)-1:0] out_msg,
    input logic [N_PORTS-1:0]         out_ready
);
    localparam int MOD_W = $clog2(N_PORTS);
    localparam int MSG_W = MOD_W + ADDR_W + 1 + DATA_W;
    localparam int HALF  = N_PORTS / 2;
    localparam int CAP   = MOD_W * N_PORTS;
    localparam int CNT_W = $clog2(CAP + 1) + 2;

    logic [CNT_W-1:0] inflight;
    logic [CNT_W-1:0] acc_cnt;
    logic [CNT_W-1:0] del_cnt;

    // Count handshakes at both edges of the network this cycle.
    always_comb begin
        acc_cnt = CNT_W'($countones(in_valid & in_ready));
        del_cnt = CNT_W'($countones(out_valid & out_ready));
    end

    // Running occupancy of the network.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + acc_cnt - del_cnt;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (out_valid == '0)); // R1

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        del_cnt <= inflight); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(CAP)); // R10

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && !out_ready[p]) |=>
            (out_valid[p] && $stable(out_msg[p*MSG_W +: MSG_W]))); // R9

        AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[p] && !in_ready[p]) |=>
            (in_valid[p] && $stable(in_msg[p*MSG_W +: MSG_W]))); // R8
    end

    // Ports j and j+HALF meet at first-rank switch j (upper and lower input).
    for (genvar j = 0; j < HALF; j++) begin : g_pair
        AST_UPPER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid[j] && in_valid[j+HALF] &&
             (in_msg[j*MSG_W + MSG_W - 1] == in_msg[(j+HALF)*MSG_W + MSG_W - 1]))
            |-> !in_ready[j+HALF]); // R7
    end
endmodule

bind omega_network omega_network_chk #(
    .N_PORTS (N_PORTS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_msg    (in_msg),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_msg   (out_msg),
    .out_ready (out_ready)
);

// File: tb/omega_network_tb.sv
// Bench: pair vectors from a table, then directed reset, full-load,
// stall and back-pressure tests.
module omega_network_tb;
    localparam int N      = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int MOD_W  = 3;
    localparam int MSG_W  = MOD_W + ADDR_W + 1 + DATA_W;
    localparam int MAXARR = 16;

    // Pair vectors {srcA, dstA, latA, srcB, dstB, latB}
    localparam logic [17:0] PAIRS [0:5] = '{
        {3'd3, 3'd6, 3'd3, 3'd1, 3'd1, 3'd3},  // disjoint paths
        {3'd0, 3'd0, 3'd3, 3'd1, 3'd1, 3'd3},  // disjoint paths
        {3'd0, 3'd0, 3'd3, 3'd4, 3'd3, 3'd4},  // clash at first rank
        {3'd2, 3'd5, 3'd3, 3'd6, 3'd5, 3'd4},  // same destination
        {3'd0, 3'd1, 3'd3, 3'd2, 3'd0, 3'd4},  // clash at second rank
        {3'd7, 3'd7, 3'd3, 3'd5, 3'd2, 3'd3}   // disjoint paths
    };

    logic                      clk = 1'b0;
    logic                      rst_n;
    logic [N-1:0]              in_valid;
    logic [N-1:0][MSG_W-1:0]   in_msg;
    logic [N-1:0]              in_ready;
    logic [N-1:0]              out_valid;
    logic [N-1:0][MSG_W-1:0]   out_msg;
    logic [N-1:0]              out_ready;

    int checks = 0;
    int errors = 0;

    int                 arr_n;
    int                 arr_port [MAXARR];
    int                 arr_cyc  [MAXARR];
    logic [MSG_W-1:0]   arr_msg  [MAXARR];
    logic [7:0]         tag_of   [N];
    logic [7:0]         next_tag = 8'h10;
    logic [N-1:0]       launch_ready;

    always #10 clk = ~clk;

    omega_network #(.N_PORTS(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_msg    (in_msg),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_msg   (out_msg),
        .out_ready (out_ready)
    );

    function automatic logic [MSG_W-MOD_W-1:0] payload(input logic [7:0] tag);
        return {tag, tag[0], tag, ~tag, tag ^ 8'h5A, 8'h3C};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Offer one message per masked source, then watch for `cycles` clock edges.
    task automatic launch(input logic [N-1:0] mask, input logic [N-1:0][2:0] dsts,
                          input int cycles);
        logic [N-1:0] acc;
        arr_n = 0;
        @(negedge clk);
        for (int s = 0; s < N; s++) begin
            tag_of[s] = next_tag;
            next_tag  = next_tag + 8'd1;
            in_msg[s] = {dsts[s], payload(tag_of[s])};
        end
        in_valid = mask;
        for (int k = 1; k <= cycles; k++) begin
            #1;
            acc = in_valid & in_ready;
            if (k == 1) launch_ready = in_ready;
            @(posedge clk);
            @(negedge clk);
            in_valid = in_valid & ~acc;
            #1;
            for (int p = 0; p < N; p++) begin
                if (out_valid[p] && out_ready[p] && arr_n < MAXARR) begin
                    arr_port[arr_n] = p;
                    arr_cyc[arr_n]  = k;
                    arr_msg[arr_n]  = out_msg[p];
                    arr_n++;
                end
            end
        end
    endtask

    // Find the message from src and check its port, cycle, return field and payload.
    task automatic check_msg(input int src, input int dst, input int lat,
                             input string lat_req, output int cyc);
        int idx = -1;
        cyc = -1;
        for (int i = 0; i < arr_n; i++)
            if (arr_msg[i][MSG_W-MOD_W-1 -: 8] == tag_of[src]) idx = i;
        chk(idx >= 0, "R10", "message delivered", 64'(idx), 64'(tag_of[src]));
        if (idx >= 0) begin
            cyc = arr_cyc[idx];
            chk(arr_port[idx] == dst, "R2", "output port", 64'(arr_port[idx]), 64'(dst));
            chk(arr_cyc[idx] == lat, lat_req, "latency", 64'(arr_cyc[idx]), 64'(lat));
            chk(arr_msg[idx][MSG_W-1 -: MOD_W] == 3'(src), "R3", "return path",
                64'(arr_msg[idx][MSG_W-1 -: MOD_W]), 64'(src));
            chk(arr_msg[idx][MSG_W-MOD_W-1:0] == payload(tag_of[src]), "R4", "payload",
                64'(arr_msg[idx][MSG_W-MOD_W-1:0]), 64'(payload(tag_of[src])));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0][2:0] dsts;
        logic [MSG_W-1:0]  m1;
        logic [MSG_W-1:0]  m2;
        logic              v1;
        logic              v2;
        int                ca;
        int                cb;
        rst_n     = 1'b0;
        in_valid  = '0;
        in_msg    = '0;
        out_ready = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: idle after reset
        chk(out_valid == '0, "R1", "out_valid after reset", 64'(out_valid), 64'(0));
        chk(in_ready == '1, "R1", "in_ready after reset", 64'(in_ready), 64'(8'hFF));

        // Table walk: pairs, with upper winner lat 3 and loser lat 4 (R5, R6, R7)
        for (int t = 0; t < 6; t++) begin
            logic [2:0] sa, da, la, sb, db, lb;
            {sa, da, la, sb, db, lb} = PAIRS[t];
            dsts = '0;
            dsts[sa] = da;
            dsts[sb] = db;
            launch((N'(1) << sa) | (N'(1) << sb), dsts, 8);
            chk(arr_n == 2, "R10", "delivery count", 64'(arr_n), 64'(2));
            check_msg(int'(sa), int'(da), int'(la), "R5", ca);
            check_msg(int'(sb), int'(db), int'(lb), (lb == 3'd3) ? "R5" : "R7", cb);
            if (la == lb)
                chk(ca == cb, "R6", "parallel delivery", 64'(cb), 64'(ca));
        end

        // Full load, identity permutation: all eight in parallel (R6)
        for (int s = 0; s < N; s++) dsts[s] = 3'(s);
        launch('1, dsts, 8);
        chk(arr_n == N, "R10", "full-load delivery count", 64'(arr_n), 64'(N));
        for (int s = 0; s < N; s++) begin
            check_msg(s, s, 3, "R6", ca);
        end

        // First-rank loser sees in_ready low at launch (R8)
        dsts = '0;
        dsts[0] = 3'd2;
        dsts[4] = 3'd1;
        launch(8'b0001_0001, dsts, 8);
        chk(launch_ready[4] == 1'b0, "R8", "loser in_ready", 64'(launch_ready[4]), 64'(0));
        chk(launch_ready[0] == 1'b1, "R8", "winner in_ready", 64'(launch_ready[0]), 64'(1));
        check_msg(4, 1, 4, "R7", cb);

        // Back-pressure on output 0: message waits steadily (R9), then leaves once (R10)
        @(negedge clk);
        out_ready[0] = 1'b0;
        dsts = '0;
        launch(8'b0000_0001, dsts, 6);
        v1 = out_valid[0];
        m1 = out_msg[0];
        repeat (3) @(negedge clk);
        #1;
        v2 = out_valid[0];
        m2 = out_msg[0];
        chk(v1 && v2, "R9", "valid held under stall", 64'({v1, v2}), 64'(3));
        chk(m1 == m2, "R9", "message stable under stall", 64'(m2), 64'(m1));
        chk(m1 == {3'd0, payload(tag_of[0])}, "R9", "held message content",
            64'(m1), 64'({3'd0, payload(tag_of[0])}));
        out_ready[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(out_valid[0] == 1'b0, "R10", "consumed once", 64'(out_valid[0]), 64'(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule